// File: doc/BRIEF.md
# Paged I2C Register Target

This block is an I2C target that gives a host access to a register space wider than one byte of address. Every register is identified by a page number and an offset within that page. A host transfer carries only the offset. The page comes from a current-page register that is reachable at the top offset of every page. The host therefore selects a page once and then issues byte, word or burst transfers inside it.

Pages below `NUM_PAGES` are backed by a byte array written so that block RAM can be inferred. Higher pages are empty. Page zero also holds a read-only identification word and two strobe registers whose bits self-clear and leave the block as one-cycle pulses. SCL and SDA are sampled by the system clock, which must run much faster than SCL. The target drives SDA only by pulling it low, through an output enable. Clock stretching and multi-master arbitration are not handled.

Top module: `paged_i2c_target`

## Requirements
- R1: A byte after START whose upper seven bits equal `DEV_ADDR` is acknowledged (SDA pulled low in the ninth clock). Any other address gets no acknowledge, and the target stays off the bus until the next START.
- R2: The current-page register resets to 0x00. A data byte written to offset 0xFF on any page, implemented or not, becomes the page for all later accesses. A read of offset 0xFF returns the current page.
- R3: A register is selected by the pair {page, offset}. The same offset on two different implemented pages holds independent values.
- R4: In a write transfer, the first data byte is the offset and each later byte is stored at the running offset. A three-byte write (offset, high, low) places the high byte at the offset and the low byte at offset+1.
- R5: A read consists of a one-byte offset write, a repeated START and a read address. Each byte read advances the offset by one, so a 128-byte burst from offset 0x00 returns that page's bytes 0x00..0x7F in order.
- R6: The running offset wraps from 0xFF to 0x00 and never changes the page. A read burst started at 0xFE returns byte 0xFE, then the current page, then byte 0x00 of the same page.
- R7: On page 0, offset 0x00 reads `ID_WORD[7:0]` (default 0x31) and offset 0x02 reads `ID_WORD[15:8]` (default 0x03). With bits 0x30 cleared, the word is 0x0301. Writes to these offsets are acknowledged and do not change them.
- R8: A write to page 0 offset 0x01 with bit 0 set gives a one-cycle pulse on `xmit_rst_o`. A write to page 0 offset 0x0A gives one-cycle pulses on `soft_rst_o[1]` (bit 1) and `soft_rst_o[0]` (bit 0). Both offsets read back 0x00.
- R9: Pages at or above `NUM_PAGES` read 0x00 at every offset except 0xFF. Writes to them are acknowledged and ignored.
- R10: The target changes its SDA drive only while SCL is low, and it releases SDA whenever it is idle.
- R11: After reset, `sda_oe_o`, `xmit_rst_o` and `soft_rst_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad (wired-AND value) |
| sda_oe_o | output | 1 | High pulls SDA low |
| xmit_rst_o | output | 1 | One-cycle transmitter reset strobe |
| soft_rst_o | output | 2 | One-cycle strobes: bit 1 for the serial side, bit 0 for audio |

## Verification
The assertions rely on SCL being slow next to `clk`. There must be at least several system cycles between SCL edges, so that a synchronized falling edge is acted on before the next rise, and no two register writes land in adjacent cycles. The assertions also rely on the host moving SDA only while SCL is low, except to form START and STOP. The bench master holds every SCL phase for ten system cycles and changes SDA a couple of cycles after SCL falls. It never issues START or STOP while the target is pulling SDA low.

// File: rtl/pi2c_pkg.sv
package pi2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_t;

  localparam logic [7:0] OFF_PAGE_SEL = 8'hFF;
  localparam logic [7:0] OFF_ID_LO    = 8'h00;
  localparam logic [7:0] OFF_XMIT_RST = 8'h01;
  localparam logic [7:0] OFF_ID_HI    = 8'h02;
  localparam logic [7:0] OFF_SOFT_RST = 8'h0A;
endpackage

// File: rtl/pi2c_sync.sv
module pi2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_p;
  logic [STAGES:0] sda_p;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_i};
      sda_p <= {sda_p[STAGES-1:0], sda_i};
    end
  end

  always_comb begin
    scl_s     = scl_p[STAGES-1];
    sda_s     = sda_p[STAGES-1];
    scl_prev  = scl_p[STAGES];
    sda_prev  = sda_p[STAGES];
    scl_rise  = scl_s & ~scl_prev;
    scl_fall  = ~scl_s & scl_prev;
    start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
  end
endmodule

// File: rtl/pi2c_engine.sv
module pi2c_engine
  import pi2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h70
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_off,
  output logic [7:0] wr_data,
  output logic [7:0] offset
);
  localparam logic [3:0] BITS = 4'd8;

  tgt_state_t state;
  logic [7:0] sh, tx;
  logic [3:0] cnt;
  logic       rw_q, first_q, nack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sh      <= '0;
      tx      <= '0;
      cnt     <= '0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      nack_q  <= 1'b1;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_off  <= '0;
      wr_data <= '0;
      offset  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == BITS) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  sda_oe  <= 1'b1;
                  rw_q    <= sh[0];
                  first_q <= 1'b1;
                  state   <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_WR_ACK;
                if (first_q) begin
                  offset  <= sh;
                  first_q <= 1'b0;
                end else begin
                  wr_en   <= 1'b1;
                  wr_off  <= offset;
                  wr_data <= sh;
                  offset  <= offset + 8'd1;
                end
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            if (rw_q) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[7];
              state  <= ST_RD;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_WR;
            end
          end
          ST_WR_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WR;
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == BITS) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                offset <= offset + 8'd1;
                state  <= ST_RD_ACK;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              if (!nack_q) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[7];
                state  <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R10: SDA drive only moves while SCL is low
  assert_sda_moves_low_R10: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  // R1: no drive while idle (unmatched address or finished transfer)
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);

  // R6: each stored byte advances the running offset by one, wrapping in 8 bits
  assert_offset_step_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (offset == wr_off + 8'd1));
endmodule

// File: rtl/pi2c_store.sv
module pi2c_store
  import pi2c_pkg::*;
#(
  parameter int          NUM_PAGES = 4,
  parameter logic [15:0] ID_WORD   = 16'h0331
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] offset,
  input  logic       wr_en,
  input  logic [7:0] wr_off,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       xmit_rst_o,
  output logic [1:0] soft_rst_o
);
  localparam int         PW       = $clog2(NUM_PAGES);
  localparam int         DEPTH    = NUM_PAGES * 256;
  localparam int         IW       = PW + 8;
  localparam logic [7:0] PAGE_LIM = 8'(NUM_PAGES);

  logic [7:0]    mem [DEPTH];
  logic [7:0]    page_q, mem_q, const_q;
  logic          use_const_q;
  logic [IW-1:0] rd_idx, wr_idx;
  logic          page_impl, page_zero, wr_special, wr_ok;

  always_comb begin
    page_impl  = page_q < PAGE_LIM;
    page_zero  = page_q == 8'h00;
    rd_idx     = {page_q[PW-1:0], offset};
    wr_idx     = {page_q[PW-1:0], wr_off};
    wr_special = (wr_off == OFF_PAGE_SEL) ||
                 (page_zero && (wr_off == OFF_ID_LO || wr_off == OFF_ID_HI ||
                                wr_off == OFF_XMIT_RST || wr_off == OFF_SOFT_RST));
    wr_ok      = wr_en && page_impl && !wr_special;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_idx] <= wr_data;
    mem_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q      <= '0;
      const_q     <= '0;
      use_const_q <= 1'b1;
      xmit_rst_o  <= 1'b0;
      soft_rst_o  <= '0;
    end else begin
      if (wr_en && wr_off == OFF_PAGE_SEL) page_q <= wr_data;
      xmit_rst_o <= wr_en && page_zero && wr_off == OFF_XMIT_RST && wr_data[0];
      soft_rst_o <= (wr_en && page_zero && wr_off == OFF_SOFT_RST) ? wr_data[1:0] : 2'b00;
      use_const_q <= 1'b1;
      if (offset == OFF_PAGE_SEL)                  const_q <= page_q;
      else if (page_zero && offset == OFF_ID_LO)   const_q <= ID_WORD[7:0];
      else if (page_zero && offset == OFF_ID_HI)   const_q <= ID_WORD[15:8];
      else if (page_zero && (offset == OFF_XMIT_RST || offset == OFF_SOFT_RST))
        const_q <= 8'h00;
      else if (!page_impl)                          const_q <= 8'h00;
      else                                          use_const_q <= 1'b0;
    end
  end

  assign rd_data = use_const_q ? const_q : mem_q;

  // R2: the page only moves after a write to the page-select offset
  assert_page_only_by_sel_R2: assert property (@(posedge clk) disable iff (rst)
    (page_q != $past(page_q)) |-> $past(wr_en && wr_off == OFF_PAGE_SEL));

  // R8: strobes are single-cycle
  assert_xmit_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    xmit_rst_o |=> !xmit_rst_o);
  assert_soft_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (soft_rst_o != 2'b00) |=> (soft_rst_o == 2'b00));
endmodule

// File: rtl/paged_i2c_target.sv
module paged_i2c_target #(
  parameter logic [6:0]  DEV_ADDR    = 7'h70,
  parameter int          NUM_PAGES   = 4,
  parameter logic [15:0] ID_WORD     = 16'h0331,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       xmit_rst_o,
  output logic [1:0] soft_rst_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [7:0] wr_off, wr_data, offset, rd_data;

  pi2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  pi2c_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data),
    .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_off(wr_off),
    .wr_data(wr_data), .offset(offset)
  );

  pi2c_store #(.NUM_PAGES(NUM_PAGES), .ID_WORD(ID_WORD)) u_store (
    .clk(clk), .rst(rst), .offset(offset), .wr_en(wr_en),
    .wr_off(wr_off), .wr_data(wr_data), .rd_data(rd_data),
    .xmit_rst_o(xmit_rst_o), .soft_rst_o(soft_rst_o)
  );
endmodule

// File: tb/tb_paged_i2c_target.sv
`timescale 1ns/1ps
module tb_paged_i2c_target;
  localparam logic [6:0] ADDR = 7'h70;
  localparam int NPG  = 4;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe, xmit_rst;
  logic [1:0] soft_rst;
  wire sda_line = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  paged_i2c_target dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .xmit_rst_o(xmit_rst), .soft_rst_o(soft_rst)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] shadow [NPG*256];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [128];
  logic [7:0] cur_pg = 8'h00;
  int x_cnt = 0, s1_cnt = 0, s0_cnt = 0, wide = 0, r10_viol = 0;
  logic prev_oe = 1'b0, prev_x = 1'b0;

  always @(posedge clk) begin
    if (!rst) begin
      if (xmit_rst) x_cnt++;
      if (soft_rst[1]) s1_cnt++;
      if (soft_rst[0]) s0_cnt++;
      if (xmit_rst && prev_x) wide++;
      if (sda_oe != prev_oe && m_scl) r10_viol++;
    end
    prev_oe = sda_oe;
    prev_x  = xmit_rst;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] pg, input logic [7:0] off);
    if (off == 8'hFF) return cur_pg;
    if (pg == 8'h00 && off == 8'h00) return 8'h31;
    if (pg == 8'h00 && off == 8'h02) return 8'h03;
    if (pg == 8'h00 && (off == 8'h01 || off == 8'h0A)) return 8'h00;
    if (pg >= 8'(NPG)) return 8'h00;
    return shadow[{pg[1:0], off}];
  endfunction

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; hw(HALF); m_scl = 1'b1; hw(HALF);
    m_sda = 1'b0; hw(HALF); m_scl = 1'b0; hw(HALF);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; hw(HALF); m_scl = 1'b1; hw(HALF); m_sda = 1'b1; hw(HALF);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hw(HALF); m_scl = 1'b1; hw(HALF); m_scl = 1'b0; hw(2);
    end
    m_sda = 1'b1; hw(HALF); m_scl = 1'b1; hw(HALF/2);
    ack = ~sda_line;
    hw(HALF/2); m_scl = 1'b0; hw(2);
  endtask

  task automatic get_byte(input logic nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(HALF); m_scl = 1'b1; hw(HALF/2); b[i] = sda_line; hw(HALF/2); m_scl = 1'b0;
    end
    hw(2); m_sda = nack; hw(HALF); m_scl = 1'b1; hw(HALF); m_scl = 1'b0; hw(2);
  endtask

  task automatic xfer_write(input string req, input logic [7:0] off, input int n);
    logic a;
    bus_start;
    put_byte({ADDR, 1'b0}, a); chk("R1 addr ack", a, 1'b1);
    put_byte(off, a);          chk({req, " offset ack"}, a, 1'b1);
    for (int i = 0; i < n; i++) begin
      put_byte(wbuf[i], a);    chk({req, " data ack"}, a, 1'b1);
    end
    bus_stop;
  endtask

  task automatic xfer_read(input logic [7:0] off, input int n);
    logic a;
    bus_start;
    put_byte({ADDR, 1'b0}, a); chk("R5 addr ack", a, 1'b1);
    put_byte(off, a);          chk("R5 offset ack", a, 1'b1);
    bus_start;
    put_byte({ADDR, 1'b1}, a); chk("R5 read addr ack", a, 1'b1);
    for (int i = 0; i < n; i++) get_byte(i == n - 1, rbuf[i]);
    bus_stop;
  endtask

  task automatic set_page(input logic [7:0] pg);
    wbuf[0] = pg;
    xfer_write("R2", 8'hFF, 1);
    cur_pg = pg;
  endtask

  task automatic model_write(input logic [7:0] off, input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] o;
      o = off + 8'(i);
      if (cur_pg < 8'(NPG) && o != 8'hFF &&
          !(cur_pg == 8'h00 && (o == 8'h00 || o == 8'h01 || o == 8'h02 || o == 8'h0A)))
        shadow[{cur_pg[1:0], o}] = wbuf[i];
    end
  endtask

  initial begin
    logic a;
    void'($urandom(32'd20240611));
    repeat (10) @(negedge clk);
    rst = 1'b0;
    hw(5);
    // R11: reset state
    chk("R11 sda_oe", sda_oe, 1'b0);
    chk("R11 xmit", xmit_rst, 1'b0);
    chk("R11 soft", soft_rst, 2'b00);
    // R2: page resets to zero
    xfer_read(8'hFF, 1);
    chk("R2 reset page", rbuf[0], 8'h00);

    // R1: foreign address is not acknowledged
    bus_start;
    put_byte({7'h21, 1'b0}, a);
    chk("R1 foreign nack", a, 1'b0);
    bus_stop;
    chk("R1 oe idle", sda_oe, 1'b0);

    // R7: identification, and write ignored
    wbuf[0] = 8'hAA;
    xfer_write("R7", 8'h00, 1);
    xfer_read(8'h00, 3);
    chk("R7 id lo", rbuf[0], 8'h31);
    chk("R8 xmit reg reads 0", rbuf[1], 8'h00);
    chk("R7 id hi", rbuf[2], 8'h03);
    chk("R7 id masked", {rbuf[2], rbuf[0]} & 16'hFFCF, 16'h0301);

    // R8: strobes
    wbuf[0] = 8'h01; xfer_write("R8", 8'h01, 1);
    chk("R8 xmit pulse count", 16'(x_cnt), 16'd1);
    wbuf[0] = 8'h03; xfer_write("R8", 8'h0A, 1);
    wbuf[0] = 8'h02; xfer_write("R8", 8'h0A, 1);
    chk("R8 soft1 count", 16'(s1_cnt), 16'd2);
    chk("R8 soft0 count", 16'(s0_cnt), 16'd1);
    chk("R8 single cycle", 16'(wide), 16'd0);
    xfer_read(8'h0A, 1);
    chk("R8 soft reg reads 0", rbuf[0], 8'h00);

    // R4: word write lands high byte first
    set_page(8'h01);
    wbuf[0] = 8'h12; wbuf[1] = 8'h34;
    xfer_write("R4", 8'h40, 2); model_write(8'h40, 2);
    xfer_read(8'h40, 2);
    chk("R4 msb", rbuf[0], 8'h12);
    chk("R4 lsb", rbuf[1], 8'h34);

    // R3: same offset, other page
    set_page(8'h02);
    wbuf[0] = 8'h77;
    xfer_write("R3", 8'h40, 1); model_write(8'h40, 1);
    xfer_read(8'h40, 1);
    chk("R3 page2", rbuf[0], 8'h77);
    set_page(8'h01);
    xfer_read(8'h40, 1);
    chk("R3 page1 kept", rbuf[0], 8'h12);

    // R6: wrap within page
    set_page(8'h02);
    wbuf[0] = 8'h5A; xfer_write("R6", 8'hFE, 1); model_write(8'hFE, 1);
    wbuf[0] = 8'h6B; xfer_write("R6", 8'h00, 1); model_write(8'h00, 1);
    xfer_read(8'hFE, 3);
    chk("R6 at FE", rbuf[0], 8'h5A);
    chk("R6 page reg", rbuf[1], 8'h02);
    chk("R6 wrapped 00", rbuf[2], 8'h6B);

    // R9: unimplemented page
    set_page(8'h90);
    wbuf[0] = 8'hC3; wbuf[1] = 8'h3C;
    xfer_write("R9", 8'h20, 2);
    xfer_read(8'h20, 2);
    chk("R9 read zero a", rbuf[0], 8'h00);
    chk("R9 read zero b", rbuf[1], 8'h00);
    xfer_read(8'hFF, 1);
    chk("R2 page readback", rbuf[0], 8'h90);

    // R5: 128-byte burst
    set_page(8'h03);
    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < 16; i++) wbuf[i] = 8'($urandom);
      xfer_write("R4", 8'(c * 16), 16);
      model_write(8'(c * 16), 16);
    end
    xfer_read(8'h00, 128);
    for (int i = 0; i < 128; i++) chk("R5 burst", rbuf[i], exp_rd(8'h03, 8'(i)));

    // Random mix over implemented and empty pages
    for (int it = 0; it < 14; it++) begin
      logic [7:0] pg, off;
      int n;
      pg  = 8'($urandom_range(6, 1));
      off = 8'($urandom_range(8'hE0, 8'h10));
      n   = $urandom_range(4, 1);
      set_page(pg);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      xfer_write("R4", off, n);
      model_write(off, n);
      xfer_read(off, n);
      for (int i = 0; i < n; i++) chk("R3/R9 random", rbuf[i], exp_rd(pg, off + 8'(i)));
    end

    chk("R10 sda moves only with scl low", 16'(r10_viol), 16'd0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule